// File: doc/BRIEF.md
# Ancillary Packet Deleter

The block sits in a 10-bit component video path downstream of packet extraction and strips out embedded ancillary packets. Every accepted word carries a channel tag: luma or chroma. Each channel is tracked on its own. When a packet is found and deletion is armed, every word of that packet is overwritten with the channel's blanking level: luma becomes 0x040 and chroma becomes 0x200. The overwrite covers the three-word flag (0x000, 0x3FF, 0x3FF), the identifier words, the count word, the user words and the checksum, which is 7 plus DC words in all. All other samples, timing reference sequences included, leave the block unchanged.

Deletion is armed by an external pin or by a configuration bit. Either one is enough. A mode-select bit must also be low. The block reads the arming state once per packet, at the word that completes the flag. Arming changes made inside a packet are therefore ignored until the next packet begins.

Both the input and the output use valid/ready handshakes. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained that cycle. While `out_valid` is high and `out_ready` is low, the output word and tag stay frozen. The control pins are plain levels.

Top module: `anc_deleter`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. The first three words a channel emits are its blanking code: 0x040 for luma (tag 0) and 0x200 for chroma (tag 1).
- R2: Channel tags leave in the order they were accepted. The n-th word accepted on a channel leaves as that channel's (n+3)-th output, and it is valid in the cycle after the accepting edge of that channel's (n+3)-th input.
- R3: When deletion is armed, each word of a packet is emitted as its channel's blanking code. The packet runs from the 0x000 of the 0x000, 0x3FF, 0x3FF flag through the checksum, 7 + DC words, where DC is bits 7:0 of the sixth word.
- R4: Deletion is armed when (`del_pin` OR `cfg_del_all`) AND NOT `cfg_del_mode`. A high `cfg_del_mode` blocks deletion even when the pin is high.
- R5: Words outside packets pass unchanged, including timing reference sequences (0x3FF, 0x000, 0x000, XYZ).
- R6: The arming state is sampled when the third flag word is accepted. A change during the rest of the packet neither stops nor starts deletion of that packet.
- R7: A packet with DC = 0 is exactly 7 words long, and the word that follows it passes unchanged.
- R8: A packet on one channel does not alter words on the other channel, even when the two channels' words are interleaved.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_chroma` hold. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: When deletion is not armed, a packet passes through word for word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 10 | Input video word |
| in_chroma | input | 1 | Input channel tag: 0 luma, 1 chroma |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 10 | Cleaned video word |
| out_chroma | output | 1 | Output channel tag |
| del_pin | input | 1 | External delete request |
| cfg_del_all | input | 1 | Configuration delete request |
| cfg_del_mode | input | 1 | Deletion mode select; must be low for full deletion |

## Verification
A word's result is not due at a fixed cycle. It comes due once three further words of the same channel have been accepted, and it then appears one register later. The bench therefore keeps one expected queue per channel, preloaded with three blanking words, and pops the matching queue whenever an output transfers. Outputs are sampled at the falling edge, where `out_valid`, `out_ready` and the data have settled. During stalls the bench compares the held word against the previous falling-edge sample to check R9.

// File: rtl/anc_del_pkg.sv
package anc_del_pkg;
  localparam int WORD_W = 10;
  localparam int LANES  = 2;
  localparam int TAG_W  = $clog2(LANES);
  localparam int DELAY  = 3;              // flag length: words held before a decision
  localparam int CNT_W  = 8;              // width of the count field

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    PS_IDLE, PS_DID, PS_SDID, PS_DC, PS_UDW, PS_CS
  } pstate_e;

  localparam word_t FLAG_LO = word_t'(10'h000);
  localparam word_t FLAG_HI = word_t'(10'h3FF);
endpackage

// File: rtl/anc_del_enable.sv
module anc_del_enable (
  input  logic del_pin,
  input  logic cfg_del_all,
  input  logic cfg_del_mode,
  output logic del_en
);
  // either request source arms full deletion; the mode bit must select it
  always_comb del_en = (del_pin | cfg_del_all) & ~cfg_del_mode;
endmodule

// File: rtl/anc_del_lane.sv
module anc_del_lane import anc_del_pkg::*; #(
  parameter word_t BLANK = word_t'(10'h040)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  word_t in_word,
  input  logic  del_en,
  output word_t pop_word
);
  word_t             line_q [DELAY];
  logic [DELAY-1:0]  del_q;
  pstate_e           st_q;
  logic [CNT_W-1:0]  left_q;
  logic              pkt_del_q;
  logic              flag_hit;

  always_comb flag_hit = (st_q == PS_IDLE) && (line_q[1] == FLAG_LO) &&
                         (line_q[0] == FLAG_HI) && (in_word == FLAG_HI);

  always_comb pop_word = del_q[DELAY-1] ? BLANK : line_q[DELAY-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DELAY; i++) line_q[i] <= BLANK;
      del_q     <= '0;
      st_q      <= PS_IDLE;
      left_q    <= '0;
      pkt_del_q <= 1'b0;
    end else if (step) begin
      for (int i = DELAY-1; i > 0; i--) begin
        line_q[i] <= line_q[i-1];
        del_q[i]  <= del_q[i-1];
      end
      line_q[0] <= in_word;
      del_q[0]  <= (st_q != PS_IDLE) ? pkt_del_q : 1'b0;
      unique case (st_q)
        PS_IDLE: if (flag_hit) begin
          del_q     <= {DELAY{del_en}};   // mark the whole flag retroactively
          pkt_del_q <= del_en;
          st_q      <= PS_DID;
        end
        PS_DID:  st_q <= PS_SDID;
        PS_SDID: st_q <= PS_DC;
        PS_DC: begin
          left_q <= in_word[CNT_W-1:0];
          st_q   <= (in_word[CNT_W-1:0] == '0) ? PS_CS : PS_UDW;
        end
        PS_UDW: begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_q <= PS_CS;
        end
        PS_CS:   st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  // R6: decision fixed for the life of a packet
  a_r6_decision_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PS_IDLE) |=> $stable(pkt_del_q));
  // R7: empty packet goes straight to checksum
  a_r7_empty_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st_q == PS_DC && in_word[CNT_W-1:0] == '0) |=> (st_q == PS_CS));
  // R3: packet ends after the checksum word
  a_r3_packet_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && st_q == PS_CS) |=> (st_q == PS_IDLE));
endmodule

// File: rtl/anc_del_outreg.sv
module anc_del_outreg import anc_del_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  word_t            ld_word,
  input  logic [TAG_W-1:0] ld_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output word_t            out_word,
  output logic [TAG_W-1:0] out_tag
);
  always_comb in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_tag   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= ld_word;
        out_tag  <= ld_tag;
      end
    end
  end

  // R9: stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_tag)));
  // R2: an accepted word yields an output in the next cycle
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/anc_deleter.sv
module anc_deleter import anc_del_pkg::*; #(
  parameter word_t LUMA_BLANK   = word_t'(10'h040),
  parameter word_t CHROMA_BLANK = word_t'(10'h200)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_chroma,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_chroma,
  input  logic              del_pin,
  input  logic              cfg_del_all,
  input  logic              cfg_del_mode
);
  logic  del_en;
  logic  accept;
  word_t pop_w [LANES];
  word_t sel_word;

  anc_del_enable u_en (
    .del_pin(del_pin), .cfg_del_all(cfg_del_all),
    .cfg_del_mode(cfg_del_mode), .del_en(del_en)
  );

  always_comb accept = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    anc_del_lane #(.BLANK(g == 0 ? LUMA_BLANK : CHROMA_BLANK)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .step(accept && (in_chroma == TAG_W'(g))),
      .in_word(in_word), .del_en(del_en), .pop_word(pop_w[g])
    );
  end

  always_comb sel_word = pop_w[in_chroma];

  anc_del_outreg u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .ld_word(sel_word), .ld_tag(in_chroma),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_tag(out_chroma)
  );
endmodule

// File: tb/tb_anc_deleter.sv
module tb_anc_deleter;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] LB = 10'h040;
  localparam logic [9:0] CB = 10'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_chroma = 1'b0, out_ready = 1'b1;
  logic [9:0] in_word = '0;
  logic del_pin = 1'b0, cfg_del_all = 1'b0, cfg_del_mode = 1'b0;
  logic in_ready, out_valid, out_chroma;
  logic [9:0] out_word;

  int checks = 0, errors = 0;
  logic [9:0] q0[$], q1[$];
  string rq0[$], rq1[$];
  logic bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic held = 1'b0;
  logic [9:0] held_word;
  logic held_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  anc_deleter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_chroma(in_chroma), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_chroma(out_chroma),
    .del_pin(del_pin), .cfg_del_all(cfg_del_all), .cfg_del_mode(cfg_del_mode)
  );

  task automatic check(input logic ok, input string rq, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  // back-pressure pattern
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_word == held_word && out_chroma == held_tag,
              "R9", out_word, held_word);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        held = 1'b1; held_word = out_word; held_tag = out_chroma;
      end
      if (out_valid && out_ready) begin
        if (out_chroma) begin
          if (q1.size() == 0) check(1'b0, "R2", out_word, 10'h0);
          else check(out_word == q1[0], rq1[0], out_word, q1[0]);
          if (q1.size() != 0) begin void'(q1.pop_front()); void'(rq1.pop_front()); end
        end else begin
          if (q0.size() == 0) check(1'b0, "R2", out_word, 10'h0);
          else check(out_word == q0[0], rq0[0], out_word, q0[0]);
          if (q0.size() != 0) begin void'(q0.pop_front()); void'(rq0.pop_front()); end
        end
      end
    end
  end

  task automatic send(input logic ch, input logic [9:0] w, input logic [9:0] exp, input string rq);
    in_valid = 1'b1; in_word = w; in_chroma = ch;
    do @(negedge clk); while (!in_ready);
    if (ch) begin q1.push_back(exp); rq1.push_back(rq); end
    else begin q0.push_back(exp); rq0.push_back(rq); end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // packet of 7+dc words; flip_at >= 0 toggles cfg_del_all after that word
  task automatic send_pkt(input logic ch, input int dc, input logic del, input int flip_at,
                          input logic mix, input string rq);
    logic [9:0] w;
    int n = 7 + dc;
    for (int i = 0; i < n; i++) begin
      if (i == 0) w = 10'h000;
      else if (i < 3) w = 10'h3FF;
      else if (i == 3) w = 10'h241;
      else if (i == 4) w = 10'h102;
      else if (i == 5) w = {2'b01, 8'(dc)};
      else if (i == n - 1) w = 10'h1AB;
      else w = 10'(10'h100 + i * 7);
      send(ch, w, del ? (ch ? CB : LB) : w, rq);
      if (i == flip_at) cfg_del_all = ~cfg_del_all;
      if (mix) send(~ch, 10'h155, 10'h155, "R8");
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R2: watchdog actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      q0.push_back(LB); rq0.push_back("R1");
      q1.push_back(CB); rq1.push_back("R1");
    end
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R1", {9'b0, out_valid}, 10'h0);
    check(in_ready, "R9", {9'b0, in_ready}, 10'h1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 / R2: plain words and a timing reference, interleaved
    send(1'b0, 10'h3FF, 10'h3FF, "R5"); send(1'b1, 10'h2A0, 10'h2A0, "R2");
    send(1'b0, 10'h000, 10'h000, "R5"); send(1'b1, 10'h1F0, 10'h1F0, "R2");
    send(1'b0, 10'h000, 10'h000, "R5"); send(1'b1, 10'h0C3, 10'h0C3, "R2");
    send(1'b0, 10'h2AC, 10'h2AC, "R5");
    for (int i = 0; i < 4; i++) send(1'b0, 10'(10'h080 + i), 10'(10'h080 + i), "R2");

    // R3: deletion via register, luma and chroma
    cfg_del_all = 1'b1;
    send_pkt(1'b0, 2, 1'b1, -1, 1'b0, "R3");
    send(1'b0, 10'h123, 10'h123, "R3");
    send_pkt(1'b1, 3, 1'b1, -1, 1'b0, "R3");
    send(1'b1, 10'h321, 10'h321, "R3");

    // R8: interleaved with other channel, under back-pressure (R9)
    bp_mode = 1'b1;
    send_pkt(1'b0, 4, 1'b1, -1, 1'b1, "R8");
    send_pkt(1'b1, 1, 1'b1, -1, 1'b1, "R8");

    // R4: pin alone, then mode bit blocks
    cfg_del_all = 1'b0; del_pin = 1'b1;
    send_pkt(1'b1, 2, 1'b1, -1, 1'b0, "R4");
    cfg_del_mode = 1'b1;
    send_pkt(1'b0, 2, 1'b0, -1, 1'b0, "R4");
    cfg_del_mode = 1'b0; del_pin = 1'b0;

    // R10: not armed
    send_pkt(1'b0, 5, 1'b0, -1, 1'b0, "R10");
    bp_mode = 1'b0;

    // R7: empty packet then a plain word
    cfg_del_all = 1'b1;
    send_pkt(1'b0, 0, 1'b1, -1, 1'b0, "R7");
    send(1'b0, 10'h3FF, 10'h3FF, "R7");
    send(1'b0, 10'h0AA, 10'h0AA, "R7");

    // R6: arming change inside a packet
    send_pkt(1'b1, 3, 1'b1, 4, 1'b0, "R6");   // starts armed, disarmed mid-way
    send_pkt(1'b0, 3, 1'b0, 3, 1'b0, "R6");   // starts disarmed, armed mid-way
    cfg_del_all = 1'b0;

    // flush
    for (int i = 0; i < 3; i++) begin
      send(1'b0, 10'h011, 10'h011, "R2");
      send(1'b1, 10'h022, 10'h022, "R2");
    end
    repeat (10) @(posedge clk);
    #1;
    check(q0.size() == 3, "R2", 10'(q0.size()), 10'd3);
    check(q1.size() == 3, "R2", 10'(q1.size()), 10'd3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule